// File: doc/BRIEF.md
# Stack Push/Pop Sequencer

This block owns the stack pointer of a CPU with a 20-bit byte address space and carries out every stack transfer on a 16-bit, little-endian, byte-addressable memory port. The CPU core hands it one command at a time. The command carries an operation code, an operand (a data value or a return address) and, for interrupt entry, the status word. The block then spends a fixed number of cycles on the memory port, with at most one access per cycle. It raises `done` for one cycle when the command is finished. Values that were popped appear on `pop_data` and `pop_sr`.

The stack grows toward lower addresses. The pointer always addresses the most recently stored item. Word and byte items take two bytes of stack. 20-bit items take four bytes: the low 16 bits go at the pointer and the top four bits go in the next word up. Interrupt entry stores two words, and interrupt return reads them back from memory as they stand at that moment. Any change a handler made to the saved status word is therefore returned.

Top module: `stk_engine`

## Requirements
- R1: A command is accepted in a cycle where `cmd_valid` is high and `busy` is low. The `cmd_op` codes are: 1 word push, 2 byte push, 3 wide push, 4 word pop, 5 byte pop, 6 wide pop, 7 call, 8 wide call, 9 return, 10 wide return, 11 interrupt entry, 12 interrupt return, 13 pointer load. Codes 0, 14 and 15 are ignored: no `busy`, no `done`, no memory request and no pointer change.
- R2: A word push lowers `sp` by 2 and then writes `cmd_data[15:0]` at the new `sp` with `mem_be` = 2'b11. Bits 7:0 go to the even (lower) byte address.
- R3: A byte push lowers `sp` by 2 and writes with `mem_be` = 2'b01, with `cmd_data[7:0]` in the low lane. The byte at `sp`+1 keeps its old value.
- R4: A word pop reads the word at `sp` and presents it zero-extended on `pop_data`. `sp` rises by 2 when the command finishes.
- R5: A byte pop presents the byte at `sp` on `pop_data` with bits 19:8 zero. `sp` rises by 2.
- R6: A wide push lowers `sp` by 4. It stores bits 15:0 at `sp` and stores bits 19:16 in bits 3:0 of the word at `sp`+2, whose upper 12 bits are zero. A wide pop rebuilds the 20-bit value and raises `sp` by 4.
- R7: A call pushes `cmd_data` as a word (`sp` minus 2). A wide call pushes it as a 20-bit item (`sp` minus 4). Return and wide return bring the stored address back on `pop_data` and restore `sp`.
- R8: Interrupt entry lowers `sp` by 4. It writes `cmd_data[15:0]` (the program counter) at `sp`+2 and `cmd_sr` at `sp`. Interrupt return puts the word at `sp` on `pop_sr` and the word at `sp`+2 on `pop_data`, using the memory contents present at the time of the return, and raises `sp` by 4.
- R9: A pointer load sets `sp` to `cmd_data` with bit 0 cleared and makes no memory access. `sp` and every `mem_addr` are always even.
- R10: Each cycle with `busy` high makes exactly one memory access. `busy` lasts 1 cycle for codes 1, 2, 4, 5, 7 and 9, 2 cycles for codes 3, 6, 8, 10, 11 and 12, and 0 cycles for code 13. `done` is high for the cycle after the last access, and a new command can be accepted in that cycle.
- R11: After reset, `sp` holds SP_RESET (0x00200 by default), and `busy`, `done` and `mem_req` are low. Read data on `mem_rdata` is taken in the same cycle as the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 4 | Operation code |
| cmd_data | input | 20 | Push operand, return address, interrupt PC or pointer load value |
| cmd_sr | input | 16 | Status word saved by interrupt entry |
| busy | output | 1 | Memory phase of a command in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 20 | Popped value or restored address |
| pop_sr | output | 16 | Status word restored by interrupt return |
| sp | output | 20 | Current stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Even byte address of the word |
| mem_be | output | 2 | Byte lane enables, bit 0 = lower address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data for the addressed word |

## Verification
Two events share one clock edge. One is the `done` cycle of a command, which comes after a pop has already moved the pointer at its last access. The other is the acceptance of the next command. The bench issues each new command in the very cycle it sees `done`, so every push that follows a pop has to address memory from the pointer value the pop just left. The pop-then-push and push-then-pop pairs are judged by the pointer value after each step, by the data read back at the expected addresses, and by the count of busy cycles for each command.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int WORD_W = 16;
    localparam int LANES  = WORD_W / 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_PUSHW = 4'd1,
        OP_PUSHB = 4'd2,
        OP_PUSHA = 4'd3,
        OP_POPW  = 4'd4,
        OP_POPB  = 4'd5,
        OP_POPA  = 4'd6,
        OP_CALL  = 4'd7,
        OP_CALLA = 4'd8,
        OP_RET   = 4'd9,
        OP_RETA  = 4'd10,
        OP_INTE  = 4'd11,
        OP_RETI  = 4'd12,
        OP_LDSP  = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } stk_op_e;

    typedef enum logic [1:0] {
        WS_LO,
        WS_HI,
        WS_BYTE,
        WS_SR
    } wsrc_e;

    typedef enum logic [1:0] {
        RD_WORD,
        RD_BYTE,
        RD_HI,
        RD_SR
    } rdst_e;

    typedef struct packed {
        logic  we;
        logic  hi;
        logic  bytewide;
        wsrc_e wsrc;
        rdst_e rdst;
    } beat_t;

    // memory beats needed by an operation
    function automatic logic [1:0] op_beats(stk_op_e op);
        case (op)
            OP_PUSHW, OP_PUSHB, OP_POPW, OP_POPB, OP_CALL, OP_RET: return 2'd1;
            OP_PUSHA, OP_POPA, OP_CALLA, OP_RETA, OP_INTE, OP_RETI: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic op_known(stk_op_e op);
        return (op_beats(op) != 2'd0) || (op == OP_LDSP);
    endfunction

    function automatic logic op_grows(stk_op_e op);
        return op inside {OP_PUSHW, OP_PUSHB, OP_PUSHA, OP_CALL, OP_CALLA, OP_INTE};
    endfunction

    function automatic logic op_shrinks(stk_op_e op);
        return op inside {OP_POPW, OP_POPB, OP_POPA, OP_RET, OP_RETA, OP_RETI};
    endfunction

    // bytes of stack taken by one item
    function automatic logic [2:0] op_frame(stk_op_e op);
        return {op_beats(op), 1'b0};
    endfunction

    // what one beat of an operation does on the memory port
    function automatic beat_t beat_plan(stk_op_e op, logic step);
        beat_t b;
        b = '{we: 1'b0, hi: 1'b0, bytewide: 1'b0, wsrc: WS_LO, rdst: RD_WORD};
        case (op)
            OP_PUSHW, OP_CALL: b.we = 1'b1;
            OP_PUSHB: begin
                b.we       = 1'b1;
                b.bytewide = 1'b1;
                b.wsrc     = WS_BYTE;
            end
            OP_PUSHA, OP_CALLA: begin
                b.we   = 1'b1;
                b.hi   = !step;
                b.wsrc = step ? WS_LO : WS_HI;
            end
            OP_INTE: begin
                b.we   = 1'b1;
                b.hi   = !step;
                b.wsrc = step ? WS_SR : WS_LO;
            end
            OP_POPB: begin
                b.bytewide = 1'b1;
                b.rdst     = RD_BYTE;
            end
            OP_POPA, OP_RETA: begin
                b.hi   = step;
                b.rdst = step ? RD_HI : RD_WORD;
            end
            OP_RETI: begin
                b.hi   = step;
                b.rdst = step ? RD_WORD : RD_SR;
            end
            default: b.rdst = RD_WORD;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_valid,
    input  stk_op_e cmd_op,
    output logic    accept,
    output logic    busy,
    output logic    done,
    output stk_op_e op_q,
    output logic    step,
    output logic    last
);

    logic busy_q, done_q, step_q;

    assign accept = cmd_valid && !busy_q && op_known(cmd_op);
    assign last   = busy_q && (({1'b0, step_q} + 2'd1) == op_beats(op_q));
    assign busy   = busy_q;
    assign done   = done_q;
    assign step   = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            step_q <= 1'b0;
            op_q   <= OP_NOP;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                op_q   <= cmd_op;
                step_q <= 1'b0;
                if (op_beats(cmd_op) == 2'd0) done_q <= 1'b1;
                else                          busy_q <= 1'b1;
            end else if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= 1'b1;
                end
            end
        end
    end

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10
    beat_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);

    // R1
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !op_known(cmd_op)) |=> (!busy && !done));

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int              ADDR_W   = 20,
    parameter logic [ADDR_W-1:0] SP_RESET = 20'h00200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              dec,
    input  logic              inc,
    input  logic [2:0]        amt,
    output logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] RST_EVEN = {SP_RESET[ADDR_W-1:1], 1'b0};

    always_ff @(posedge clk) begin
        if (rst)      sp <= RST_EVEN;
        else if (ld)  sp <= {ld_val[ADDR_W-1:1], 1'b0};
        else if (dec) sp <= sp - ADDR_W'(amt);
        else if (inc) sp <= sp + ADDR_W'(amt);
    end

    // R9
    sp_even_chk: assert property (@(posedge clk) disable iff (rst)
        !sp[0]);

endmodule

// File: rtl/stk_xfer.sv
module stk_xfer
    import stk_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  stk_op_e           op_q,
    input  logic              step,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] data_q,
    input  logic [WORD_W-1:0] sr_q,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pop_data,
    output logic [WORD_W-1:0] pop_sr
);

    localparam int EXT_W = ADDR_W - WORD_W;

    beat_t plan;

    always_comb begin
        plan      = beat_plan(op_q, step);
        mem_req   = busy;
        mem_we    = busy && plan.we;
        mem_addr  = plan.hi ? sp + ADDR_W'(LANES) : sp;
        mem_be    = plan.bytewide ? LANES'(1) : '1;
        case (plan.wsrc)
            WS_HI:   mem_wdata = WORD_W'(data_q[ADDR_W-1:WORD_W]);
            WS_BYTE: mem_wdata = WORD_W'(data_q[7:0]);
            WS_SR:   mem_wdata = sr_q;
            default: mem_wdata = data_q[WORD_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_data <= '0;
            pop_sr   <= '0;
        end else if (busy && !plan.we) begin
            case (plan.rdst)
                RD_BYTE: pop_data <= ADDR_W'(mem_rdata[7:0]);
                RD_HI:   pop_data[ADDR_W-1:WORD_W] <= mem_rdata[EXT_W-1:0];
                RD_SR:   pop_sr <= mem_rdata;
                default: pop_data <= ADDR_W'(mem_rdata);
            endcase
        end
    end

    // R9
    addr_even_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]);

    // R10
    req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we);

endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter logic [ADDR_W-1:0] SP_RESET = 20'h00200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_data,
    input  logic [15:0]       cmd_sr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pop_data,
    output logic [15:0]       pop_sr,
    output logic [ADDR_W-1:0] sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);

    stk_op_e           op_in, op_q;
    logic              accept, step, last;
    logic [ADDR_W-1:0] data_q;
    logic [WORD_W-1:0] sr_q;
    logic              sp_ld, sp_dec, sp_inc;
    logic [2:0]        sp_amt;

    assign op_in  = stk_op_e'(cmd_op);
    assign sp_ld  = accept && (op_in == OP_LDSP);
    assign sp_dec = accept && op_grows(op_in);
    assign sp_inc = last && op_shrinks(op_q);
    assign sp_amt = sp_dec ? op_frame(op_in) : op_frame(op_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            sr_q   <= '0;
        end else if (accept) begin
            data_q <= cmd_data;
            sr_q   <= cmd_sr;
        end
    end

    stk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_in),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .op_q      (op_q),
        .step      (step),
        .last      (last)
    );

    stk_ptr #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (sp_ld),
        .ld_val (cmd_data),
        .dec    (sp_dec),
        .inc    (sp_inc),
        .amt    (sp_amt),
        .sp     (sp)
    );

    stk_xfer #(.ADDR_W(ADDR_W)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .op_q      (op_q),
        .step      (step),
        .sp        (sp),
        .data_q    (data_q),
        .sr_q      (sr_q),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .pop_data  (pop_data),
        .pop_sr    (pop_sr)
    );

    // R2
    push_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op_grows(op_in)) |=> (sp == $past(sp) - ADDR_W'(op_frame($past(op_in)))));

    // R10
    sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> $stable(sp));

    // R3
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && op_q == OP_PUSHB) |-> (mem_be == 2'b01));

    // R4
    pop_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (last && op_shrinks(op_q)) |=> (sp == $past(sp) + ADDR_W'(op_frame($past(op_q)))));

endmodule

// File: tb/sim_stk_engine.sv
module sim_stk_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 17;

    typedef struct packed {
        logic [3:0]  op;
        logic [19:0] data;
        logic [15:0] sr;
        logic [19:0] exp_sp;
        logic [19:0] exp_rd;
        logic [15:0] exp_sr;
        logic        chk_rd;
        logic        chk_sr;
        logic [1:0]  nbeat;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd1,  20'h01234, 16'h0, 20'h001FE, 20'h0,     16'h0,    1'b0, 1'b0, 2'd1}, // R2
        '{4'd2,  20'h0ABCD, 16'h0, 20'h001FC, 20'h0,     16'h0,    1'b0, 1'b0, 2'd1}, // R3
        '{4'd4,  20'h0,     16'h0, 20'h001FE, 20'h05ACD, 16'h0,    1'b1, 1'b0, 2'd1}, // R3 R4
        '{4'd5,  20'h0,     16'h0, 20'h00200, 20'h00034, 16'h0,    1'b1, 1'b0, 2'd1}, // R5
        '{4'd3,  20'hABCDE, 16'h0, 20'h001FC, 20'h0,     16'h0,    1'b0, 1'b0, 2'd2}, // R6
        '{4'd4,  20'h0,     16'h0, 20'h001FE, 20'h0BCDE, 16'h0,    1'b1, 1'b0, 2'd1}, // R6
        '{4'd4,  20'h0,     16'h0, 20'h00200, 20'h0000A, 16'h0,    1'b1, 1'b0, 2'd1}, // R6
        '{4'd3,  20'h54321, 16'h0, 20'h001FC, 20'h0,     16'h0,    1'b0, 1'b0, 2'd2}, // R6
        '{4'd6,  20'h0,     16'h0, 20'h00200, 20'h54321, 16'h0,    1'b1, 1'b0, 2'd2}, // R6
        '{4'd7,  20'h04466, 16'h0, 20'h001FE, 20'h0,     16'h0,    1'b0, 1'b0, 2'd1}, // R7
        '{4'd9,  20'h0,     16'h0, 20'h00200, 20'h04466, 16'h0,    1'b1, 1'b0, 2'd1}, // R7
        '{4'd8,  20'hF1234, 16'h0, 20'h001FC, 20'h0,     16'h0,    1'b0, 1'b0, 2'd2}, // R7
        '{4'd10, 20'h0,     16'h0, 20'h00200, 20'hF1234, 16'h0,    1'b1, 1'b0, 2'd2}, // R7
        '{4'd11, 20'h08ACE, 16'h0183, 20'h001FC, 20'h0,  16'h0,    1'b0, 1'b0, 2'd2}, // R8
        '{4'd12, 20'h0,     16'h0, 20'h00200, 20'h08ACE, 16'h0183, 1'b1, 1'b1, 2'd2}, // R8
        '{4'd13, 20'h00301, 16'h0, 20'h00300, 20'h0,     16'h0,    1'b0, 1'b0, 2'd0}, // R9
        '{4'd13, 20'h00200, 16'h0, 20'h00200, 20'h0,     16'h0,    1'b0, 1'b0, 2'd0}  // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [19:0] cmd_data = '0;
    logic [15:0] cmd_sr = '0;
    logic        busy, done, mem_req, mem_we;
    logic [19:0] pop_data, sp, mem_addr;
    logic [15:0] pop_sr, mem_wdata, mem_rdata;
    logic [1:0]  mem_be;

    logic        poke_en = 1'b0;
    logic [8:0]  poke_idx = '0;
    logic [15:0] poke_val = '0;
    logic [15:0] mem [512];

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_engine u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_sr(cmd_sr), .busy(busy), .done(done),
        .pop_data(pop_data), .pop_sr(pop_sr), .sp(sp), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[9:1]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 512; i++) mem[i] <= 16'h5A5A;
        end else if (poke_en) begin
            mem[poke_idx] <= poke_val;
        end else if (mem_req && mem_we) begin
            if (mem_be[0]) mem[mem_addr[9:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[9:1]][15:8] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // issue at a negedge, return at the negedge where done is seen
    task automatic run(input logic [3:0] op, input logic [19:0] d, input logic [15:0] s,
                       output int nbusy);
        nbusy     = 0;
        cmd_op    = op;
        cmd_data  = d;
        cmd_sr    = s;
        cmd_valid = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (busy) nbusy++;
            if (done) break;
        end
    endtask

    task automatic poke(input logic [19:0] addr, input logic [15:0] val);
        poke_idx = addr[9:1];
        poke_val = val;
        poke_en  = 1'b1;
        @(negedge clk);
        poke_en  = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        int nb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 sp", 32'(sp), 32'h200);
        chk("R11 busy", 32'(busy), 0);
        chk("R11 done", 32'(done), 0);
        chk("R11 mem_req", 32'(mem_req), 0);

        // table walk, each command issued in the done cycle of the previous
        for (int i = 0; i < NVEC; i++) begin
            run(VECS[i].op, VECS[i].data, VECS[i].sr, nb);
            chk($sformatf("vec%0d sp", i), 32'(sp), 32'(VECS[i].exp_sp));
            chk($sformatf("vec%0d R10 beats", i), nb, 32'(VECS[i].nbeat));
            if (VECS[i].chk_rd) chk($sformatf("vec%0d pop_data", i), 32'(pop_data), 32'(VECS[i].exp_rd));
            if (VECS[i].chk_sr) chk($sformatf("vec%0d pop_sr", i), 32'(pop_sr), 32'(VECS[i].exp_sr));
        end

        // R8 interrupt frame layout left in memory
        chk("R8 pc word at sp+2", 32'(mem[9'h0FF]), 32'h8ACE);
        chk("R8 sr word at sp", 32'(mem[9'h0FE]), 32'h0183);

        // R8 status word edited in memory before return
        run(4'd11, 20'h01111, 16'h00F0, nb);
        poke(20'h001FC, 16'h0007);
        run(4'd12, 20'h0, 16'h0, nb);
        chk("R8 edited sr", 32'(pop_sr), 32'h0007);
        chk("R8 pc", 32'(pop_data), 32'h01111);
        chk("R8 sp", 32'(sp), 32'h200);

        // R3 byte push keeps high byte of word at sp (0x11 from earlier pc)
        run(4'd2, 20'h00077, 16'h0, nb);
        chk("R3 word after byte push", 32'(mem[9'h0FF]), 32'h1177);
        chk("R3 sp", 32'(sp), 32'h1FE);
        run(4'd5, 20'h0, 16'h0, nb);
        chk("R5 byte pop", 32'(pop_data), 32'h77);

        // R1 reserved codes ignored
        for (int c = 0; c < 3; c++) begin
            logic [3:0] code;
            code = (c == 0) ? 4'd0 : (c == 1) ? 4'd14 : 4'd15;
            cmd_op    = code;
            cmd_data  = 20'h00100;
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (2) begin
                chk("R1 busy", 32'(busy), 0);
                chk("R1 done", 32'(done), 0);
                chk("R1 mem_req", 32'(mem_req), 0);
                @(negedge clk);
            end
            chk("R1 sp", 32'(sp), 32'h200);
        end

        // R9 odd load value is forced even, then a push below it
        run(4'd13, 20'h00155, 16'h0, nb);
        chk("R9 sp even", 32'(sp), 32'h154);
        run(4'd1, 20'h0BEEF, 16'h0, nb);
        chk("R2 word at new sp", 32'(mem[9'h0A9]), 32'hBEEF);
        chk("R2 sp", 32'(sp), 32'h152);

        summary();
        $finish;
    end

endmodule